// File: doc/BRIEF.md
# Two-Pass Scan Access to a Debug Register Bank

This block lets an external scan host read and write a small bank of 32-bit debug registers using only the data-register scan path of a test access port. The path is armed by one 10-bit emulation command. While any other command is loaded, the block ignores all scan activity and holds its output low.

Once armed, every register access takes two scan passes. The first pass shifts in an 8-bit selection word that names a register and says whether the access is a read or a write. The second pass moves 32 bits of data. For a read, the capture step of that pass loads the chosen register so that it shifts out on the serial output. For a write, the update step of that pass stores the bits that were shifted in. A phase flag flips on each update step, so selection passes and data passes alternate. When the block stores a value it also raises a one-cycle write notification that carries the register index and the data, so that neighbouring logic can act on the new setting.

The bank holds `NUM_REGS` registers at consecutive indices starting at `BASE_IDX`. With the defaults these are indices 0x10 to 0x13. Index 0x13 is the data-trace end-address register. Every other index reads as zero and cannot be written.

Top module: `dbg_scan_access`

## Requirements
- R1: After a synchronous reset, the selection word is 0x00, the phase is the selection phase, every bank register is zero, `wr_stb_o` is low, and `tdo_o` is 0.
- R2: Scan inputs act only while `cmd_i` equals 10'b00_0111_1100. With any other command, capture, shift and update do nothing, `tdo_o` is 0 and no write takes place.
- R3: While enabled, each `upd_dr_i` cycle flips the phase between selection and data. An access is therefore one selection pass followed by one data pass.
- R4: In the selection phase, a shift cycle moves the 8-bit selection register one place toward bit 0, taking `tdi_i` into bit 7. After 8 shifts the first bit sent is in bit 0. Bits 7:1 are the register index. Bit 0 is the direction: 1 means write and 0 means read.
- R5: In the data phase of a read, `cap_dr_i` loads the selected register into the 32-bit data shifter. `tdo_o` then shows bit 0 of the shifter, and each shift cycle moves the shifter toward bit 0, so the value leaves LSB first.
- R6: In the data phase of a write, `upd_dr_i` stores the 32 shifted bits (first bit sent lands in bit 0) into the selected register. In the next cycle `wr_stb_o` is high for exactly one cycle, with `wr_idx_o` and `wr_data_o` showing the index and the value.
- R7: An index outside `BASE_IDX`..`BASE_IDX+NUM_REGS-1` reads as all zeros. A write to such an index changes no register and raises no strobe.
- R8: Whenever `cmd_i` differs from the enabling value, the phase returns to selection. A selection pass left without its data pass is abandoned when the command changes.
- R9: With the defaults, indices 0x10, 0x11, 0x12 and 0x13 each hold an independent 32-bit value. Index 0x13 is the trace end-address register.
- R10: During a selection pass, `tdo_o` shifts out the previous selection word LSB first, and a capture in the selection phase leaves that word unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cmd_i | input | 10 | Loaded emulation command |
| cap_dr_i | input | 1 | Capture-DR state indication |
| shift_dr_i | input | 1 | Shift-DR state indication |
| upd_dr_i | input | 1 | Update-DR state indication |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out |
| wr_stb_o | output | 1 | One-cycle pulse after a register write |
| wr_idx_o | output | 7 | Index of the written register |
| wr_data_o | output | 32 | Value written |

## Verification
A phase flag in the wrong state turns a selection pass into a data pass. The next read then returns the wrong value, or a write strobe fires after an 8-bit pass, within the same access. A corrupted selection word shows up on `tdo_o` at the start of the next selection pass, because the old word shifts out there. A bank register that is wrong, or that was written when it should not have been, appears on `tdo_o` the next time that register is read. The bench sweeps all 128 indices, first writing and then reading, so any aliasing between implemented and unimplemented indices shows up during the read sweep.

// File: rtl/dbgacc_pkg.sv
package dbgacc_pkg;
  localparam int CMD_W = 10;
  localparam logic [CMD_W-1:0] ACCESS_CMD = 10'b00_0111_1100;
  localparam int SEL_W = 8;
  localparam int IDX_W = SEL_W - 1;

  typedef struct packed {
    logic [IDX_W-1:0] idx;
    logic             wr;
  } sel_t;
endpackage

// File: rtl/dbgacc_sel_shift.sv
module dbgacc_sel_shift
  import dbgacc_pkg::*;
#(
  parameter int W = SEL_W
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         shift_en,
  input  logic         tdi_i,
  output logic [W-1:0] sel_q
);
  always_ff @(posedge clk_i) begin
    if (rst_i) sel_q <= '0;
    else if (shift_en) sel_q <= {tdi_i, sel_q[W-1:1]};
  end
endmodule

// File: rtl/dbgacc_data_shift.sv
module dbgacc_data_shift #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         cap_en,
  input  logic [W-1:0] cap_val,
  input  logic         shift_en,
  input  logic         tdi_i,
  output logic [W-1:0] data_q
);
  always_ff @(posedge clk_i) begin
    if (rst_i) data_q <= '0;
    else if (cap_en) data_q <= cap_val;
    else if (shift_en) data_q <= {tdi_i, data_q[W-1:1]};
  end
endmodule

// File: rtl/dbgacc_bank.sv
module dbgacc_bank
  import dbgacc_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 4,
  parameter int BASE_IDX = 16
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              hit_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int LAST_IDX = BASE_IDX + NUM_REGS - 1;

  logic [DATA_W-1:0] regs_q [NUM_REGS];

  assign hit_o = (int'(idx_i) >= BASE_IDX) && (int'(idx_i) <= LAST_IDX);

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (hit_o && (int'(idx_i) == BASE_IDX + i)) rdata_o = regs_q[i];
  end

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rst_i) regs_q[i] <= '0;
      else if (we_i && hit_o && (int'(idx_i) == BASE_IDX + i)) regs_q[i] <= wdata_i;
    end
  end
endmodule

// File: rtl/dbg_scan_access.sv
module dbg_scan_access
  import dbgacc_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 4,
  parameter int BASE_IDX = 16
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic              cap_dr_i,
  input  logic              shift_dr_i,
  input  logic              upd_dr_i,
  input  logic              tdi_i,
  output logic              tdo_o,
  output logic              wr_stb_o,
  output logic [IDX_W-1:0]  wr_idx_o,
  output logic [DATA_W-1:0] wr_data_o
);
  logic              en;
  logic              phase_q;
  logic [SEL_W-1:0]  sel_q;
  sel_t              sel;
  logic [DATA_W-1:0] data_q;
  logic [DATA_W-1:0] rdata;
  logic              hit;
  logic              we;

  assign en  = (cmd_i == ACCESS_CMD);
  assign sel = sel_t'(sel_q);

  always_ff @(posedge clk_i) begin
    if (rst_i || !en) phase_q <= 1'b0;
    else if (upd_dr_i) phase_q <= ~phase_q;
  end

  dbgacc_sel_shift #(.W(SEL_W)) u_sel (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .shift_en (en && shift_dr_i && !phase_q),
    .tdi_i    (tdi_i),
    .sel_q    (sel_q)
  );

  dbgacc_bank #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .BASE_IDX(BASE_IDX)) u_bank (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .idx_i   (sel.idx),
    .we_i    (we),
    .wdata_i (data_q),
    .hit_o   (hit),
    .rdata_o (rdata)
  );

  dbgacc_data_shift #(.W(DATA_W)) u_data (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .cap_en   (en && cap_dr_i && phase_q && !sel.wr),
    .cap_val  (rdata),
    .shift_en (en && shift_dr_i && phase_q),
    .tdi_i    (tdi_i),
    .data_q   (data_q)
  );

  assign we = en && upd_dr_i && phase_q && sel.wr && hit;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      wr_stb_o  <= 1'b0;
      wr_idx_o  <= '0;
      wr_data_o <= '0;
    end else begin
      wr_stb_o <= we;
      if (we) begin
        wr_idx_o  <= sel.idx;
        wr_data_o <= data_q;
      end
    end
  end

  assign tdo_o = en && (phase_q ? data_q[0] : sel_q[0]);
endmodule

// File: rtl/dbgacc_chk.sv
module dbgacc_chk
  import dbgacc_pkg::*;
#(
  parameter int NUM_REGS = 4,
  parameter int BASE_IDX = 16
) (
  input logic             clk_i,
  input logic             rst_i,
  input logic [CMD_W-1:0] cmd_i,
  input logic             shift_dr_i,
  input logic             upd_dr_i,
  input logic             tdi_i,
  input logic             phase_q,
  input logic [SEL_W-1:0] sel_q,
  input logic             wr_stb_o,
  input logic [IDX_W-1:0] wr_idx_o
);
  localparam int LAST_IDX = BASE_IDX + NUM_REGS - 1;

  // R1
  rst_clear_chk: assert property (@(posedge clk_i)
    rst_i |=> (sel_q == '0 && !phase_q && !wr_stb_o));

  // R2
  disabled_idle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (cmd_i != ACCESS_CMD) |=> (!phase_q && !wr_stb_o));

  // R3
  phase_toggle_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (cmd_i == ACCESS_CMD && upd_dr_i) |=> (phase_q != $past(phase_q)));

  // R4
  sel_shift_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (cmd_i == ACCESS_CMD && shift_dr_i && !phase_q) |=>
      (sel_q[SEL_W-2:0] == $past(sel_q[SEL_W-1:1]) && sel_q[SEL_W-1] == $past(tdi_i)));

  // R6
  strobe_cause_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_stb_o |-> $past(upd_dr_i && phase_q && sel_q[0]));

  // R7
  strobe_range_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    wr_stb_o |-> (int'(wr_idx_o) >= BASE_IDX && int'(wr_idx_o) <= LAST_IDX));
endmodule

bind dbg_scan_access dbgacc_chk #(.NUM_REGS(NUM_REGS), .BASE_IDX(BASE_IDX)) u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .cmd_i      (cmd_i),
  .shift_dr_i (shift_dr_i),
  .upd_dr_i   (upd_dr_i),
  .tdi_i      (tdi_i),
  .phase_q    (phase_q),
  .sel_q      (sel_q),
  .wr_stb_o   (wr_stb_o),
  .wr_idx_o   (wr_idx_o)
);

// File: tb/test_dbg_scan_access.sv
module test_dbg_scan_access;
  localparam int CLK_P = 10;
  localparam logic [9:0] EN_CMD = 10'b00_0111_1100;
  localparam int BASE = 16;
  localparam int NREG = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [9:0]  cmd = '0;
  logic        cap = 1'b0, shft = 1'b0, upd = 1'b0, tdi = 1'b0;
  logic        tdo, stb;
  logic [6:0]  widx;
  logic [31:0] wdat;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [31:0] model [128];
  logic [7:0]  prev_sel = 8'h00;

  always #(CLK_P/2) clk = ~clk;

  dbg_scan_access i_dbg_scan_access (
    .clk_i(clk), .rst_i(rst), .cmd_i(cmd), .cap_dr_i(cap), .shift_dr_i(shft),
    .upd_dr_i(upd), .tdi_i(tdi), .tdo_o(tdo), .wr_stb_o(stb),
    .wr_idx_o(widx), .wr_data_o(wdat)
  );

  function automatic bit impl(input int idx);
    return idx >= BASE && idx < BASE + NREG;
  endfunction

  function automatic logic [31:0] pat(input int idx);
    return (32'h9E37_79B9 * (idx + 1)) ^ {idx[7:0], 24'h00_5A_C3};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic scan(input int n, input logic [31:0] din, output logic [31:0] dout);
    dout = '0;
    @(negedge clk); cap = 1'b1;
    @(negedge clk); cap = 1'b0;
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      tdi = din[i];
      shft = 1'b1;
      @(negedge clk);
    end
    shft = 1'b0; upd = 1'b1;
    @(negedge clk); upd = 1'b0;
  endtask

  task automatic access(input int idx, input bit wr, input logic [31:0] wval);
    logic [31:0] so, d;
    logic [7:0] s;
    s = {idx[6:0], wr};
    scan(8, {24'h0, s}, so);
    check("R10 old selection out", {24'h0, so[7:0]}, {24'h0, prev_sel});
    check("R3 no strobe after selection pass", {31'h0, stb}, 32'h0);
    prev_sel = s;
    scan(32, wval, d);
    if (!wr) begin
      if (impl(idx)) check("R5 read data", d, model[idx]);
      else           check("R7 unimplemented reads zero", d, 32'h0);
    end else begin
      if (impl(idx)) begin
        check("R6 strobe", {31'h0, stb}, 32'h1);
        check("R6 strobe index", {25'h0, widx}, idx);
        check("R6 strobe data", wdat, wval);
        model[idx] = wval;
      end else begin
        check("R7 unimplemented write no strobe", {31'h0, stb}, 32'h0);
      end
      @(negedge clk);
      check("R6 strobe one cycle", {31'h0, stb}, 32'h0);
    end
  endtask

  initial begin
    logic [31:0] dd;
    for (int i = 0; i < 128; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cmd = EN_CMD;
    @(negedge clk);
    check("R1 reset tdo", {31'h0, tdo}, 32'h0);
    check("R1 reset strobe", {31'h0, stb}, 32'h0);
    access(8'h13, 1'b0, '0);

    // R9 / R6 / R7: write sweep over every index
    for (int i = 0; i < 128; i++) access(i, 1'b1, pat(i));
    // R9 / R5 / R7: read sweep
    for (int i = 0; i < 128; i++) access(i, 1'b0, '0);

    // R2: near-miss commands must be ignored
    for (int b = 0; b < 10; b++) begin
      cmd = EN_CMD ^ (10'h1 << b);
      @(negedge clk);
      check("R2 tdo low while disabled", {31'h0, tdo}, 32'h0);
      scan(8, 32'h27, dd);
      check("R2 no output while disabled", dd, 32'h0);
      scan(32, 32'hDEAD_BEEF, dd);
      check("R2 no strobe while disabled", {31'h0, stb}, 32'h0);
    end
    cmd = EN_CMD;
    access(8'h13, 1'b0, '0);

    // R8: abandoned selection pass, then command change
    scan(8, {24'h0, 7'h12, 1'b1}, dd);
    prev_sel = {7'h12, 1'b1};
    @(negedge clk); cmd = 10'h000;
    @(negedge clk); cmd = EN_CMD;
    @(negedge clk);
    access(8'h11, 1'b0, '0);
    access(8'h12, 1'b0, '0);

    // R6 boundary values on the end-address register
    access(8'h13, 1'b1, 32'hFFFF_FFFF);
    access(8'h13, 1'b0, '0);
    access(8'h13, 1'b1, 32'h0000_0000);
    access(8'h13, 1'b0, '0);
    access(8'h10, 1'b0, '0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule